// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps in-flight instructions in program order so that producing a result and making it architecturally visible are two separate events. An instruction enters at the tail with its kind and destination. The entry index it receives serves as its rename tag. Later, a result broadcast writes the value into that entry by tag and marks it done. Only the oldest entry, at the head, may retire, and only once its result is present. Retirement becomes a register write strobe for register and load instructions, a memory write strobe for stores, and nothing for a branch that was predicted correctly.

When the oldest entry is a finished branch that was flagged as mispredicted, it does not retire. Every entry is discarded, both pointers return to index 0, and a one-cycle flush pulse follows so that neighbouring blocks can drop their tags. Two combinational lookup ports let operand fetch read the speculative value and done flag of any entry.

The issue port is a valid/ready stream. An instruction transfers in a cycle where both `issue_valid` and `issue_ready` are high. The source must hold its payload while ready is low, and `issue_tag` is only meaningful in the transfer cycle. Ready goes low when all entries are occupied, in the cycle a flush is decided, and in the flush pulse cycle. The result broadcast and the commit strobes are plain, one-cycle, unacknowledged signals.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `issue_ready` is 1, `issue_tag` is 0, `flush`, `reg_we` and `mem_we` are 0, and both lookup ports report not-ready.
- R2: An issue transfers only when valid and ready are both high. The tag it returns is the tail index, and tags advance 0,1,…,7 and wrap to 0. After 8 entries are held, `issue_ready` is 0.
- R3: A broadcast with `cdb_valid` high stores `cdb_value` in the live entry named by `cdb_tag` and marks it done, visible through lookup from the next cycle. A broadcast to a tag that holds no live entry leaves that index reading not-ready.
- R4: Entries retire strictly from the head. While the head is not done, no commit strobe fires, even when younger entries are done.
- R5: `issue_kind` is encoded as 2'b00 register op, 2'b01 load, 2'b10 store and 2'b11 branch. A done head of kind register op or load raises `reg_we` for that cycle, with `reg_waddr` set to its destination, `reg_wdata` set to its value, and `mem_we` low.
- R6: A done store head raises `mem_we` for that cycle, with `mem_waddr` set to its destination, `mem_wdata` set to its value, and `reg_we` low. Stores therefore reach memory in program order.
- R7: A done branch head whose broadcast carried `cdb_mispredict`=0 retires without either strobe, and the next entry retires in the following cycle.
- R8: A done branch head whose broadcast carried `cdb_mispredict`=1 raises no strobe and drops `issue_ready` in that cycle. In the next cycle `flush` is 1 for exactly one cycle, every entry reads not-ready and `issue_ready` stays 0. After that, issue resumes with tag 0.
- R9: An issue and a retirement in the same cycle leave the occupancy unchanged. With 7 entries held, one such cycle plus one further issue is accepted, and after that `issue_ready` is 0.
- R10: The two lookup ports act independently. Each returns the done flag and value of the entry at its own index, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Issue request |
| issue_ready | output | 1 | Buffer can accept an issue |
| issue_kind | input | 2 | Instruction kind (R5 encoding) |
| issue_dest | input | DEST_W | Register number or memory address |
| issue_tag | output | PTR_W | Entry index assigned to this issue |
| cdb_valid | input | 1 | Result broadcast strobe |
| cdb_tag | input | PTR_W | Entry the result belongs to |
| cdb_value | input | DATA_W | Result or store data |
| cdb_mispredict | input | 1 | Branch outcome differs from prediction |
| lk0_idx | input | PTR_W | Lookup port 0 index |
| lk0_ready | output | 1 | Lookup port 0 entry live and done |
| lk0_value | output | DATA_W | Lookup port 0 value |
| lk1_idx | input | PTR_W | Lookup port 1 index |
| lk1_ready | output | 1 | Lookup port 1 entry live and done |
| lk1_value | output | DATA_W | Lookup port 1 value |
| reg_we | output | 1 | Register write strobe at commit |
| reg_waddr | output | DEST_W | Register number written |
| reg_wdata | output | DATA_W | Register data written |
| mem_we | output | 1 | Memory write strobe at commit |
| mem_waddr | output | DEST_W | Memory address written |
| mem_wdata | output | DATA_W | Memory data written |
| flush | output | 1 | One-cycle pulse after a misprediction |

## Verification
The bench fills the buffer completely and then delivers the results youngest first. A design that retired any entry as soon as it was done would raise strobes before the head finished and would write in the wrong order. It repeats this over three rotations of the kind mix with the pointers at different offsets, so a wrong wrap or a swapped strobe shows up as a wrong address or data on retirement. It also issues into a buffer while its head retires, which catches an occupancy count that loses or gains an entry and lets a ninth issue through. Around a mispredicted branch it checks the exact cycle of the flush pulse, that completed younger entries vanish, and that tags restart from 0, which exposes a flush that is late, lasts too long or leaves the tail behind.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    RK_REG    = 2'b00,
    RK_LOAD   = 2'b01,
    RK_STORE  = 2'b10,
    RK_BRANCH = 2'b11
  } rob_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (clear) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= bump(tail);
      if (pop)  head <= bump(head);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign full = (count == CNT_W'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0)); // R4
  AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push); // R2
endmodule

// File: rtl/rob_entries.sv
module rob_entries
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DEST_W = 8,
  parameter int DATA_W = 16,
  parameter int NRD    = 2,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              alloc,
  input  logic [PTR_W-1:0]  alloc_idx,
  input  rob_kind_e         alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  input  logic              wb_en,
  input  logic [PTR_W-1:0]  wb_idx,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              wb_mis,
  input  logic              retire,
  input  logic [PTR_W-1:0]  head_idx,
  input  logic [PTR_W-1:0]  rd_idx   [NRD],
  output logic              rd_ready [NRD],
  output logic [DATA_W-1:0] rd_data  [NRD],
  output logic              head_live,
  output logic              head_done,
  output logic              head_mis,
  output rob_kind_e         head_kind,
  output logic [DEST_W-1:0] head_dest,
  output logic [DATA_W-1:0] head_data
);
  logic [DEPTH-1:0]  live_q, done_q, mis_q;
  rob_kind_e         kind_q [DEPTH];
  logic [DEST_W-1:0] dest_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  logic wb_hit;
  assign wb_hit = wb_en && live_q[wb_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      done_q <= '0;
      mis_q  <= '0;
    end else if (clear) begin
      live_q <= '0;
      done_q <= '0;
      mis_q  <= '0;
    end else begin
      if (wb_hit) begin
        done_q[wb_idx] <= 1'b1;
        mis_q[wb_idx]  <= wb_mis;
      end
      if (retire) live_q[head_idx] <= 1'b0;
      if (alloc) begin
        live_q[alloc_idx] <= 1'b1;
        done_q[alloc_idx] <= 1'b0;
        mis_q[alloc_idx]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      kind_q[alloc_idx] <= alloc_kind;
      dest_q[alloc_idx] <= alloc_dest;
    end
    if (wb_hit) data_q[wb_idx] <= wb_data;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_ready[g] = live_q[rd_idx[g]] && done_q[rd_idx[g]];
    assign rd_data[g]  = data_q[rd_idx[g]];
  end

  assign head_live = live_q[head_idx];
  assign head_done = done_q[head_idx];
  assign head_mis  = mis_q[head_idx];
  assign head_kind = kind_q[head_idx];
  assign head_dest = dest_q[head_idx];
  assign head_data = data_q[head_idx];

  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !live_q[alloc_idx]); // R2
  AST_RETIRE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (live_q[head_idx] && done_q[head_idx])); // R4
endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DEST_W = 8,
  parameter int DATA_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [1:0]        issue_kind,
  input  logic [DEST_W-1:0] issue_dest,
  output logic [PTR_W-1:0]  issue_tag,
  input  logic              cdb_valid,
  input  logic [PTR_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              cdb_mispredict,
  input  logic [PTR_W-1:0]  lk0_idx,
  output logic              lk0_ready,
  output logic [DATA_W-1:0] lk0_value,
  input  logic [PTR_W-1:0]  lk1_idx,
  output logic              lk1_ready,
  output logic [DATA_W-1:0] lk1_value,
  output logic              reg_we,
  output logic [DEST_W-1:0] reg_waddr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              mem_we,
  output logic [DEST_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              flush
);
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic              full, push, retire, kill, flush_q;
  logic              h_live, h_done, h_mis;
  rob_kind_e         h_kind;
  logic [DEST_W-1:0] h_dest;
  logic [DATA_W-1:0] h_data;
  logic [PTR_W-1:0]  rd_idx   [2];
  logic              rd_ready [2];
  logic [DATA_W-1:0] rd_data  [2];

  logic h_fin;
  assign h_fin  = h_live && h_done;
  assign kill   = h_fin && (h_kind == RK_BRANCH) && h_mis;
  assign retire = h_fin && !kill;

  assign issue_ready = !full && !kill && !flush_q;
  assign push        = issue_valid && issue_ready;
  assign issue_tag   = tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= kill;
  end
  assign flush = flush_q;

  assign reg_we    = retire && ((h_kind == RK_REG) || (h_kind == RK_LOAD));
  assign reg_waddr = h_dest;
  assign reg_wdata = h_data;
  assign mem_we    = retire && (h_kind == RK_STORE);
  assign mem_waddr = h_dest;
  assign mem_wdata = h_data;

  assign rd_idx[0] = lk0_idx;
  assign rd_idx[1] = lk1_idx;
  assign lk0_ready = rd_ready[0];
  assign lk0_value = rd_data[0];
  assign lk1_ready = rd_ready[1];
  assign lk1_value = rd_data[1];

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .clear(kill), .push(push), .pop(retire),
    .head(head), .tail(tail), .count(count), .full(full)
  );

  rob_entries #(.DEPTH(DEPTH), .DEST_W(DEST_W), .DATA_W(DATA_W), .NRD(2)) u_ent (
    .clk(clk), .rst_n(rst_n), .clear(kill),
    .alloc(push), .alloc_idx(tail), .alloc_kind(rob_kind_e'(issue_kind)),
    .alloc_dest(issue_dest),
    .wb_en(cdb_valid), .wb_idx(cdb_tag), .wb_data(cdb_value), .wb_mis(cdb_mispredict),
    .retire(retire), .head_idx(head),
    .rd_idx(rd_idx), .rd_ready(rd_ready), .rd_data(rd_data),
    .head_live(h_live), .head_done(h_done), .head_mis(h_mis),
    .head_kind(h_kind), .head_dest(h_dest), .head_data(h_data)
  );

  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (count == '0)); // R8
  AST_FLUSH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!reg_we && !mem_we)); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && mem_we)); // R6
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> !issue_ready); // R2
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (!reg_we && !mem_we)); // R4
endmodule

// File: tb/sim_spec_rob.sv
module sim_spec_rob;
  import rob_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, issue_valid, issue_ready, cdb_valid, cdb_mispredict;
  logic [1:0]  issue_kind;
  logic [7:0]  issue_dest, reg_waddr, mem_waddr;
  logic [2:0]  issue_tag, cdb_tag, lk0_idx, lk1_idx;
  logic [15:0] cdb_value, lk0_value, lk1_value, reg_wdata, mem_wdata;
  logic        lk0_ready, lk1_ready, reg_we, mem_we, flush;

  spec_rob u0 (.*);

  int checks = 0, errors = 0;
  logic [1:0]  mk [8];
  logic [7:0]  md [8];
  logic [15:0] mv [8];
  int exp_head = 0, exp_tail = 0, cnt = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] d, input logic [15:0] v);
    @(negedge clk);
    issue_valid = 1'b1; issue_kind = k; issue_dest = d;
    #1;
    chk("R2", "issue_ready", int'(issue_ready), 1);
    chk("R2", "issue_tag", int'(issue_tag), exp_tail);
    mk[exp_tail] = k; md[exp_tail] = d; mv[exp_tail] = v;
    @(posedge clk); #1;
    issue_valid = 1'b0;
    exp_tail = (exp_tail + 1) % 8;
    cnt++;
  endtask

  task automatic bcast(input int tag, input logic [15:0] v, input logic mis);
    @(negedge clk);
    cdb_valid = 1'b1; cdb_tag = 3'(tag); cdb_value = v; cdb_mispredict = mis;
    @(posedge clk); #1;
    cdb_valid = 1'b0; cdb_mispredict = 1'b0;
  endtask

  task automatic check_commit();
    logic [1:0] k;
    @(negedge clk); #1;
    k = mk[exp_head];
    if (k == RK_REG || k == RK_LOAD) begin
      chk("R5", "reg_we", int'(reg_we), 1);
      chk("R5", "mem_we", int'(mem_we), 0);
      chk("R5", "reg_waddr", int'(reg_waddr), int'(md[exp_head]));
      chk("R5", "reg_wdata", int'(reg_wdata), int'(mv[exp_head]));
    end else if (k == RK_STORE) begin
      chk("R6", "mem_we", int'(mem_we), 1);
      chk("R6", "reg_we", int'(reg_we), 0);
      chk("R6", "mem_waddr", int'(mem_waddr), int'(md[exp_head]));
      chk("R6", "mem_wdata", int'(mem_wdata), int'(mv[exp_head]));
    end else begin
      chk("R7", "reg_we", int'(reg_we), 0);
      chk("R7", "mem_we", int'(mem_we), 0);
    end
    exp_head = (exp_head + 1) % 8;
    cnt--;
  endtask

  // Results delivered youngest first; commits must still come out oldest first.
  task automatic drain();
    int n;
    n = cnt;
    for (int i = n - 1; i >= 0; i--) begin
      int tag;
      tag = (exp_head + i) % 8;
      bcast(tag, mv[tag], 1'b0);
      if (i > 0) begin
        lk0_idx = 3'(tag);
        lk1_idx = 3'((exp_head + i - 1) % 8);
        #1;
        chk("R3", "lk0_ready", int'(lk0_ready), 1);
        chk("R10", "lk0_value", int'(lk0_value), int'(mv[tag]));
        chk("R10", "lk1_ready", int'(lk1_ready), 0);
        chk("R4", "reg_we head pending", int'(reg_we), 0);
        chk("R4", "mem_we head pending", int'(mem_we), 0);
      end
    end
    repeat (n) check_commit();
  endtask

  task automatic full_probe(input string req);
    @(negedge clk);
    issue_valid = 1'b1; #1;
    chk(req, "issue_ready when full", int'(issue_ready), 0);
    issue_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a_tag, c_tag;
    rst_n = 1'b0; issue_valid = 1'b0; issue_kind = '0; issue_dest = '0;
    cdb_valid = 1'b0; cdb_tag = '0; cdb_value = '0; cdb_mispredict = 1'b0;
    lk0_idx = '0; lk1_idx = 3'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "issue_ready", int'(issue_ready), 1);
    chk("R1", "issue_tag", int'(issue_tag), 0);
    chk("R1", "flush", int'(flush), 0);
    chk("R1", "reg_we", int'(reg_we), 0);
    chk("R1", "mem_we", int'(mem_we), 0);
    chk("R1", "lk0_ready", int'(lk0_ready), 0);
    chk("R1", "lk1_ready", int'(lk1_ready), 0);

    // Broadcast to an index with no live entry is dropped.
    bcast(5, 16'h1234, 1'b0);
    lk0_idx = 3'd5; #1;
    chk("R3", "dead-tag lookup ready", int'(lk0_ready), 0);

    // Full sweeps with rotating kind mix.
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 8; i++)
        push(2'((i + r) % 3), 8'(16 * r + i), 16'(r * 1000 + i * 37 + 5));
      full_probe("R2");
      drain();
    end

    // Same-cycle issue and commit.
    for (int i = 0; i < 7; i++) push(RK_REG, 8'(40 + i), 16'(700 + i));
    bcast(exp_head, mv[exp_head], 1'b0);
    @(negedge clk);
    issue_valid = 1'b1; issue_kind = RK_STORE; issue_dest = 8'd99;
    #1;
    chk("R9", "reg_we during issue", int'(reg_we), 1);
    chk("R9", "reg_wdata", int'(reg_wdata), int'(mv[exp_head]));
    chk("R9", "issue_ready", int'(issue_ready), 1);
    chk("R9", "issue_tag", int'(issue_tag), exp_tail);
    mk[exp_tail] = RK_STORE; md[exp_tail] = 8'd99; mv[exp_tail] = 16'd4242;
    @(posedge clk); #1;
    issue_valid = 1'b0;
    exp_head = (exp_head + 1) % 8;
    exp_tail = (exp_tail + 1) % 8;
    push(RK_LOAD, 8'd77, 16'd3131);
    full_probe("R9");
    drain();

    // Correctly predicted branch.
    push(RK_REG, 8'd3, 16'd11);
    push(RK_BRANCH, 8'd0, 16'd0);
    push(RK_STORE, 8'd9, 16'd22);
    drain();

    // Mispredicted branch.
    a_tag = exp_head;
    push(RK_REG, 8'd5, 16'd501);
    push(RK_BRANCH, 8'd0, 16'd0);
    c_tag = exp_tail;
    push(RK_REG, 8'd6, 16'd601);
    push(RK_STORE, 8'd7, 16'd701);
    bcast((a_tag + 3) % 8, 16'd701, 1'b0);
    bcast(c_tag, 16'd601, 1'b0);
    bcast((a_tag + 1) % 8, 16'd0, 1'b1);
    bcast(a_tag, 16'd501, 1'b0);
    check_commit();
    @(negedge clk); #1;
    chk("R8", "reg_we at bad branch", int'(reg_we), 0);
    chk("R8", "mem_we at bad branch", int'(mem_we), 0);
    chk("R8", "issue_ready at bad branch", int'(issue_ready), 0);
    chk("R8", "flush early", int'(flush), 0);
    @(negedge clk);
    lk0_idx = 3'(c_tag); #1;
    chk("R8", "flush pulse", int'(flush), 1);
    chk("R8", "issue_ready in flush", int'(issue_ready), 0);
    chk("R8", "younger entry discarded", int'(lk0_ready), 0);
    chk("R8", "store not written", int'(mem_we), 0);
    @(negedge clk); #1;
    chk("R8", "flush ends", int'(flush), 0);
    chk("R8", "issue_ready after flush", int'(issue_ready), 1);
    chk("R8", "tag restarts", int'(issue_tag), 0);
    exp_head = 0; exp_tail = 0; cnt = 0;
    push(RK_REG, 8'd7, 16'd555);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule